// File: doc/BRIEF.md
# I2C Addressed Slave Port

This block lets local logic appear on a two-wire I2C bus as a slave with one 7-bit address, set by an input. It oversamples SCL and SDA with the system clock. It detects start, repeated start and stop conditions. The first byte of every frame is compared with the configured address, and the direction bit in that byte then selects one of two modes: receive, where the master writes to the slave, or transmit, where the master reads from it.

The local side sees two byte streams with valid/ready handshakes. Bytes the slave receives appear on one stream. Bytes it must send are taken from the other. The bus wires are open drain. The block only reports when it wants to pull SCL or SDA low, and the pad logic performs the pull. If the local side cannot keep up, the slave holds SCL low, which pauses the master until the local side catches up.

Top module: `i2c_slv_port`

## Requirements
- R1: While rst_ni is low, scl_low_o, sda_low_o, rx_valid_o and tx_ready_o are all 0.
- R2: The first byte after a start is taken MSB first: bits 7..1 are the address and bit 0 is the direction. When bits 7..1 equal own_addr_i, the slave pulls SDA low during the ninth clock. On a mismatch it leaves SDA released and ignores the bus until the next start or stop, so it gives no acknowledge and delivers no data.
- R3: With direction 0, each following byte is assembled MSB first and presented on rx_data_o with rx_valid_o. The slave acknowledges the byte, and rx_valid_o and rx_data_o stay unchanged until rx_ready_i is 1.
- R4: The slave changes sda_low_o only while SCL is low, so its own SDA never makes a start or stop.
- R5: If a received byte is still pending when the eighth bit of the next byte ends, the slave holds SCL low. It keeps holding until the pending byte is taken, then presents the new byte and acknowledges it.
- R6: With direction 1, the slave acknowledges the address, takes a byte through tx_valid_i/tx_ready_o, and sends it MSB first. A master acknowledge (SDA low on the ninth clock) makes it fetch and send the next byte. tx_ready_o is high only while SCL is low.
- R7: If no byte is offered when one is due, the slave holds SCL low until tx_valid_i rises, then sends that byte.
- R8: A master not-acknowledge ends the transmission. The slave releases SDA and takes no further bytes until the next start.
- R9: A repeated start discards any partly received byte, and address matching starts again for the new frame, in either direction.
- R10: A stop returns the slave to idle with both bus pulls released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_low_o | output | 1 | 1 pulls SCL low (stretching) |
| sda_low_o | output | 1 | 1 pulls SDA low |
| own_addr_i | input | 7 | Slave address to match |
| rx_data_o | output | DATA_W | Received byte |
| rx_valid_o | output | 1 | rx_data_o holds an unread byte |
| rx_ready_i | input | 1 | Local side takes the byte |
| tx_data_i | input | DATA_W | Byte to send |
| tx_valid_i | input | 1 | tx_data_i is available |
| tx_ready_o | output | 1 | Slave takes tx_data_i this cycle |

## Verification
The bench uses the default byte width of 8 and two synchronizer stages. With these values the stretch decisions fall about three system cycles after each SCL edge. A master model that leaves eight cycles per quarter bit therefore exercises every stretch, acknowledge and abort path at full bus timing, without long runs. The master model follows the open-drain bus levels, so a held SCL really stalls it. This lets the bench check stretching in both directions by the effect on the transfer, not only by reading the pull output.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX, ST_RX_HOLD, ST_RX_ACK,
    ST_TX_HOLD, ST_TX, ST_TX_ACK, ST_IGNORE
  } slv_state_e;

  typedef struct packed {
    logic rise;
    logic fall;
    logic start;
    logic stop;
    logic sda;
  } bus_ev_t;
endpackage

// File: rtl/i2c_slv_sync.sv
module i2c_slv_sync
  import i2c_slv_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;
  logic scl_s, sda_s;

  assign scl_s = scl_sh[STAGES-1];
  assign sda_s = sda_sh[STAGES-1];

  // idle bus reads high, so the chain resets to 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh[0] <= scl_i;
      sda_sh[0] <= sda_i;
      for (int k = 1; k < STAGES; k++) begin
        scl_sh[k] <= scl_sh[k-1];
        sda_sh[k] <= sda_sh[k-1];
      end
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign ev_o.rise  = scl_s & ~scl_q;
  assign ev_o.fall  = ~scl_s & scl_q;
  assign ev_o.start = scl_s & scl_q & sda_q & ~sda_s;
  assign ev_o.stop  = scl_s & scl_q & ~sda_q & sda_s;
  assign ev_o.sda   = sda_s;
endmodule

// File: rtl/i2c_slv_engine.sv
module i2c_slv_engine
  import i2c_slv_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = DATA_W - 1,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_ev_t           ev_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              scl_low_o,
  output logic              sda_low_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  slv_state_e        st;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic              rw_q, nack_q;
  logic              byte_done, rx_free, fetch_pt, tx_take;

  assign byte_done = (bit_cnt == LAST);
  assign rx_free   = ~rx_valid_o | rx_ready_i;
  // points where the next transmit byte is due
  assign fetch_pt  = (ev_i.fall && ((st == ST_ADDR_ACK && rw_q) ||
                                    (st == ST_TX_ACK && !nack_q)))
                   || st == ST_TX_HOLD;
  assign tx_ready_o = fetch_pt;
  assign tx_take    = fetch_pt & tx_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st         <= ST_IDLE;
      shreg      <= '0;
      bit_cnt    <= '0;
      rw_q       <= 1'b0;
      nack_q     <= 1'b0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
      scl_low_o  <= 1'b0;
      sda_low_o  <= 1'b0;
    end else begin
      if (rx_valid_o && rx_ready_i) rx_valid_o <= 1'b0;
      if (ev_i.start) begin
        st        <= ST_ADDR;
        bit_cnt   <= '0;
        scl_low_o <= 1'b0;
        sda_low_o <= 1'b0;
      end else if (ev_i.stop) begin
        st        <= ST_IDLE;
        scl_low_o <= 1'b0;
        sda_low_o <= 1'b0;
      end else if (tx_take) begin
        shreg     <= tx_data_i;
        sda_low_o <= ~tx_data_i[DATA_W-1];
        scl_low_o <= 1'b0;
        bit_cnt   <= '0;
        st        <= ST_TX;
      end else if (fetch_pt) begin
        scl_low_o <= 1'b1;
        sda_low_o <= 1'b0;
        st        <= ST_TX_HOLD;
      end else begin
        unique case (st)
          ST_ADDR, ST_RX: begin
            if (ev_i.rise && !byte_done) begin
              shreg   <= {shreg[DATA_W-2:0], ev_i.sda};
              bit_cnt <= bit_cnt + CNT_W'(1);
            end else if (ev_i.fall && byte_done) begin
              if (st == ST_ADDR) begin
                if (shreg[DATA_W-1:1] == own_addr_i) begin
                  sda_low_o <= 1'b1;
                  rw_q      <= shreg[0];
                  st        <= ST_ADDR_ACK;
                end else begin
                  st <= ST_IGNORE;
                end
              end else if (rx_free) begin
                rx_data_o  <= shreg;
                rx_valid_o <= 1'b1;
                sda_low_o  <= 1'b1;
                st         <= ST_RX_ACK;
              end else begin
                scl_low_o <= 1'b1;
                st        <= ST_RX_HOLD;
              end
            end
          end
          ST_RX_HOLD: if (rx_free) begin
            rx_data_o  <= shreg;
            rx_valid_o <= 1'b1;
            sda_low_o  <= 1'b1;
            scl_low_o  <= 1'b0;
            st         <= ST_RX_ACK;
          end
          ST_ADDR_ACK, ST_RX_ACK: if (ev_i.fall) begin
            sda_low_o <= 1'b0;
            bit_cnt   <= '0;
            st        <= ST_RX;
          end
          ST_TX: begin
            if (ev_i.rise) begin
              bit_cnt <= bit_cnt + CNT_W'(1);
            end else if (ev_i.fall) begin
              if (byte_done) begin
                sda_low_o <= 1'b0;
                st        <= ST_TX_ACK;
              end else begin
                shreg     <= {shreg[DATA_W-2:0], 1'b0};
                sda_low_o <= ~shreg[DATA_W-2];
              end
            end
          end
          ST_TX_ACK: begin
            if (ev_i.rise) nack_q <= ev_i.sda;
            else if (ev_i.fall && nack_q) st <= ST_IGNORE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_slv_port.sv
module i2c_slv_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_low_o,
  output logic              sda_low_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o
);
  i2c_slv_pkg::bus_ev_t ev;

  i2c_slv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .ev_o  (ev)
  );

  i2c_slv_engine #(.DATA_W(DATA_W)) u_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_i      (ev),
    .own_addr_i(own_addr_i),
    .rx_data_o (rx_data_o),
    .rx_valid_o(rx_valid_o),
    .rx_ready_i(rx_ready_i),
    .tx_data_i (tx_data_i),
    .tx_valid_i(tx_valid_i),
    .tx_ready_o(tx_ready_o),
    .scl_low_o (scl_low_o),
    .sda_low_o (sda_low_o)
  );
endmodule

// File: rtl/i2c_slv_port_chk.sv
module i2c_slv_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_i,
  input logic              scl_low_o,
  input logic              sda_low_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_valid_o,
  input logic              rx_ready_i,
  input logic              tx_ready_o
);
  p_sda_moves_scl_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_low_o) |-> !$past(scl_i));

  p_rx_held_until_taken_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));

  p_stretch_from_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_low_o) |-> !$past(scl_i));

  p_fetch_scl_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> !scl_i);
endmodule

bind i2c_slv_port i2c_slv_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_i     (scl_i),
  .scl_low_o (scl_low_o),
  .sda_low_o (sda_low_o),
  .rx_data_o (rx_data_o),
  .rx_valid_o(rx_valid_o),
  .rx_ready_i(rx_ready_i),
  .tx_ready_o(tx_ready_o)
);

// File: tb/i2c_slv_port_tb.sv
module i2c_slv_port_tb;
  localparam int Q = 8;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic s_scl_low, s_sda_low;
  logic scl_bus, sda_bus;
  assign scl_bus = ~(m_scl_low | s_scl_low);
  assign sda_bus = ~(m_sda_low | s_sda_low);

  logic [7:0] rx_data, tx_data = 8'h00;
  logic rx_valid, tx_ready;
  logic rx_ready = 1'b1, tx_valid = 1'b0, tx_en = 1'b1;
  logic [7:0] tx_q[$];
  logic [7:0] rx_got[$];
  int checks = 0, fails = 0;
  logic prev_scl = 1'b1, prev_sda = 1'b0;

  i2c_slv_port u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .scl_i     (scl_bus),
    .sda_i     (sda_bus),
    .scl_low_o (s_scl_low),
    .sda_low_o (s_sda_low),
    .own_addr_i(OWN),
    .rx_data_o (rx_data),
    .rx_valid_o(rx_valid),
    .rx_ready_i(rx_ready),
    .tx_data_i (tx_data),
    .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // local side models
  always @(posedge clk) if (rx_valid && rx_ready) rx_got.push_back(rx_data);
  always @(posedge clk) if (tx_valid && tx_ready) void'(tx_q.pop_front());
  always @(negedge clk) begin
    tx_valid = tx_en && (tx_q.size() != 0);
    tx_data  = tx_valid ? tx_q[0] : 8'h00;
  end

  // per-clock reference: slave SDA frozen while SCL stays high (R4)
  always @(negedge clk) begin
    if (rst_n && prev_scl && scl_bus) begin
      checks++;
      if (s_sda_low !== prev_sda) begin
        fails++;
        $display("FAIL R4 sda pull moved with SCL high: actual %0b expected %0b", s_sda_low, prev_sda);
      end
    end
    prev_scl = scl_bus;
    prev_sda = s_sda_low;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    m_scl_low = 1'b0;
    @(negedge clk);
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic clock_bit(input logic b, output logic r);
    m_sda_low = ~b;
    wait_n(Q);
    scl_up();
    wait_n(Q);
    r = sda_bus;
    wait_n(Q);
    m_scl_low = 1'b1;
    wait_n(Q);
  endtask

  task automatic do_start();
    m_sda_low = 1'b0; m_scl_low = 1'b0; wait_n(Q);
    m_sda_low = 1'b1; wait_n(Q);
    m_scl_low = 1'b1; wait_n(Q);
  endtask

  task automatic do_rstart();
    m_sda_low = 1'b0; wait_n(Q);
    scl_up(); wait_n(Q);
    m_sda_low = 1'b1; wait_n(Q);
    m_scl_low = 1'b1; wait_n(Q);
  endtask

  task automatic do_stop();
    m_sda_low = 1'b1; wait_n(Q);
    scl_up(); wait_n(Q);
    m_sda_low = 1'b0; wait_n(Q);
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], r);
    clock_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, r);
      v[i] = r;
    end
    clock_bit(~mack, r);
  endtask

  initial begin
    logic ack, ack2, r;
    logic [7:0] v;

    wait_n(5);
    chk("R1 scl pull in reset", s_scl_low, 0);
    chk("R1 sda pull in reset", s_sda_low, 0);
    chk("R1 rx_valid in reset", rx_valid, 0);
    chk("R1 tx_ready in reset", tx_ready, 0);
    rst_n = 1'b1;
    wait_n(5);

    // master write to own address
    do_start();
    write_byte({OWN, 1'b0}, ack);
    chk("R2 own address acked", ack, 1);
    write_byte(8'hA5, ack);
    chk("R3 byte 1 acked", ack, 1);
    write_byte(8'h3C, ack);
    chk("R3 byte 2 acked", ack, 1);
    do_stop();
    wait_n(10);
    chk("R3 rx count", rx_got.size(), 2);
    chk("R3 rx byte 1", rx_got[0], 8'hA5);
    chk("R3 rx byte 2", rx_got[1], 8'h3C);
    chk("R10 scl released after stop", s_scl_low, 0);
    chk("R10 sda released after stop", s_sda_low, 0);
    rx_got.delete();

    // wrong address
    do_start();
    write_byte({7'h11, 1'b0}, ack);
    chk("R2 foreign address not acked", ack, 0);
    write_byte(8'hFF, ack);
    chk("R2 data after mismatch not acked", ack, 0);
    do_stop();
    wait_n(10);
    chk("R2 nothing delivered on mismatch", rx_got.size(), 0);

    // receive stretch
    rx_ready = 1'b0;
    do_start();
    write_byte({OWN, 1'b0}, ack);
    write_byte(8'h11, ack);
    chk("R5 first byte acked", ack, 1);
    fork
      write_byte(8'h22, ack2);
      begin
        for (int k = 0; k < 600; k++) begin
          if (s_scl_low) break;
          @(negedge clk);
        end
        chk("R5 SCL held while byte pending", s_scl_low, 1);
        wait_n(50);
        chk("R5 SCL still held", s_scl_low, 1);
        chk("R5 pending byte unchanged", rx_data, 8'h11);
        rx_ready = 1'b1;
      end
    join
    chk("R5 second byte acked after release", ack2, 1);
    do_stop();
    wait_n(10);
    chk("R5 rx count", rx_got.size(), 2);
    chk("R5 rx order 1", rx_got[0], 8'h11);
    chk("R5 rx order 2", rx_got[1], 8'h22);
    rx_got.delete();

    // master read, ends with not-acknowledge
    tx_q.push_back(8'hC3);
    tx_q.push_back(8'h7E);
    do_start();
    write_byte({OWN, 1'b1}, ack);
    chk("R6 read address acked", ack, 1);
    read_byte(1'b1, v);
    chk("R6 first tx byte", v, 8'hC3);
    read_byte(1'b0, v);
    chk("R6 second tx byte", v, 8'h7E);
    tx_q.push_back(8'h55);
    wait_n(40);
    chk("R8 no fetch after nack", tx_q.size(), 1);
    chk("R8 sda released after nack", s_sda_low, 0);
    clock_bit(1'b1, r);
    chk("R8 slave silent after nack", r, 1);
    do_stop();
    tx_q.delete();
    wait_n(10);

    // transmit stretch
    tx_en = 1'b0;
    tx_q.push_back(8'h96);
    do_start();
    write_byte({OWN, 1'b1}, ack);
    chk("R7 read address acked", ack, 1);
    fork
      read_byte(1'b0, v);
      begin
        for (int k = 0; k < 600; k++) begin
          if (s_scl_low) break;
          @(negedge clk);
        end
        chk("R7 SCL held without tx byte", s_scl_low, 1);
        wait_n(50);
        chk("R7 SCL still held", s_scl_low, 1);
        tx_en = 1'b1;
      end
    join
    chk("R7 byte sent after stretch", v, 8'h96);
    do_stop();
    wait_n(10);

    // repeated start aborts partial byte and re-matches
    tx_q.push_back(8'h81);
    do_start();
    write_byte({OWN, 1'b0}, ack);
    chk("R9 write address acked", ack, 1);
    clock_bit(1'b1, r);
    clock_bit(1'b0, r);
    clock_bit(1'b1, r);
    do_rstart();
    write_byte({OWN, 1'b1}, ack);
    chk("R9 read address acked after rstart", ack, 1);
    read_byte(1'b0, v);
    chk("R9 tx byte after rstart", v, 8'h81);
    do_stop();
    wait_n(10);
    chk("R9 partial byte discarded", rx_got.size(), 0);

    do_start();
    write_byte({7'h2B, 1'b0}, ack);
    chk("R9 foreign address not acked", ack, 0);
    do_rstart();
    write_byte({OWN, 1'b0}, ack);
    chk("R9 rematch after rstart", ack, 1);
    write_byte(8'h6D, ack);
    do_stop();
    wait_n(10);
    chk("R9 rx count after rematch", rx_got.size(), 1);
    chk("R9 rx byte after rematch", rx_got[0], 8'h6D);
    chk("R10 idle after final stop", s_scl_low, 0);

    finish_run();
  end
endmodule